// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block is the digital transmit path of a 100 Mb/s twisted-pair port. It takes one 4-bit nibble from the MAC every five bit clocks, together with a transmit-enable and a transmit-error flag. It turns each nibble into a 5-bit code group. When no frame is in progress it sends idle groups instead. It adds the start and end delimiters around each frame. It then sends the code group out one bit per bit clock, scrambles that bit stream with a stream cipher, converts it to NRZI and maps the result onto a three-level MLT-3 line level.

The block runs on a single bit clock. It raises a nibble tick for one cycle in every five, and the nibble inputs are taken at the end of that cycle. The scrambler state is seeded from a 5-bit port address during reset, so ports that sit side by side send different scrambled sequences. Four static controls let each conversion stage (code-group encoding, scrambling, NRZI and MLT-3) be bypassed on its own, for applications that need only part of the chain.

Top module: `tx100_sym_enc`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `level_o` is 0 and `nib_tick_o` is 0. The first code group sent after reset is idle.
- R2: Each code group is shifted out MSB first, one bit per clock, five bits per group. `nib_tick_o` is high in the 5th, 10th, 15th, … cycle after reset is released. The nibble inputs are taken at the end of each tick cycle, and the code group built from them starts on the next cycle. A serial bit reaches `level_o` two cycles after it is shifted out.
- R3: Outside a frame, with `tx_en_i` low, the idle group 11111 is sent.
- R4: A frame opens when `tx_en_i` is seen high outside a frame. The first two nibbles of the frame are replaced by 11000 and then 10001, whatever their value and whatever `tx_er_i` holds.
- R5: Inside a frame each data nibble is encoded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: Inside a frame, a nibble with both `tx_en_i` and `tx_er_i` high is sent as 00100.
- R7: The first nibble slot with `tx_en_i` low after a frame sends 01101, and the slot after it sends 00111. The `tx_en_i` value in that second slot is ignored. A new frame can open from the slot after it.
- R8: The scrambler is an 11-bit shift register, loaded during reset with six ones above `seed_i`. Each clock its key bit is bit 10 XOR bit 8 (x^11 + x^9 + 1). The register shifts left, taking the key bit into bit 0, and each serial bit is XORed with the key bit.
- R9: The NRZI stage inverts its output for every input one and holds it for every input zero. Its output is 0 after reset.
- R10: The MLT-3 stage steps through the levels 0, +1, 0, −1 on every NRZI one and holds on every zero. It starts at 0. `level_o` is coded 00 for 0, 01 for +1 and 11 for −1, and never shows 10.
- R11: Bypass controls: `byp_code_i` sends `{tx_er_i, txd_i}` as the raw group with no framing. `byp_scr_i` skips the XOR while the cipher keeps running. `byp_nrzi_i` passes bits through the NRZI stage unchanged. `byp_mlt_i` drives 01 for a one and 00 for a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en_i | input | 1 | Frame enable for the current nibble |
| tx_er_i | input | 1 | Error flag for the current nibble |
| txd_i | input | 4 | Transmit nibble |
| seed_i | input | SEED_W | Port address used as the scrambler seed, loaded during reset |
| byp_code_i | input | 1 | Bypass code-group encoding and framing |
| byp_scr_i | input | 1 | Bypass scrambling |
| byp_nrzi_i | input | 1 | Bypass NRZI conversion |
| byp_mlt_i | input | 1 | Bypass MLT-3 mapping |
| nib_tick_o | output | 1 | Nibble inputs are taken at the end of this cycle |
| level_o | output | 2 | Signed line level: 00 = 0, 01 = +1, 11 = −1 |

## Verification
The bench builds the block with its default parameters: an 11-bit cipher with its feedback tap at bit 8 and a 5-bit seed. With these values a run of a few hundred cycles covers every data code, both delimiter pairs, the error code and back-to-back frames. Different seeds show that the loaded state differs only in its low five bits, and an all-zero seed shows that the six ones above it keep the cipher running. With every later stage bypassed, the raw code groups can be read directly at the output. The bench then turns on one stage at a time: the cipher, then NRZI, then MLT-3.

// File: rtl/tx_enc_pkg.sv
package tx_enc_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    localparam logic [CG_W-1:0] CG_IDLE  = 5'b11111;
    localparam logic [CG_W-1:0] CG_SSD1  = 5'b11000;
    localparam logic [CG_W-1:0] CG_SSD2  = 5'b10001;
    localparam logic [CG_W-1:0] CG_ESD1  = 5'b01101;
    localparam logic [CG_W-1:0] CG_ESD2  = 5'b00111;
    localparam logic [CG_W-1:0] CG_HALT  = 5'b00100;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_SSD2 = 2'd1,
        FR_DATA = 2'd2,
        FR_ESD2 = 2'd3
    } frame_st_e;

    function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] nib);
        logic [CG_W-1:0] cg;
        case (nib)
            4'h0: cg = 5'b11110;
            4'h1: cg = 5'b01001;
            4'h2: cg = 5'b10100;
            4'h3: cg = 5'b10101;
            4'h4: cg = 5'b01010;
            4'h5: cg = 5'b01011;
            4'h6: cg = 5'b01110;
            4'h7: cg = 5'b01111;
            4'h8: cg = 5'b10010;
            4'h9: cg = 5'b10011;
            4'hA: cg = 5'b10110;
            4'hB: cg = 5'b10111;
            4'hC: cg = 5'b11010;
            4'hD: cg = 5'b11011;
            4'hE: cg = 5'b11100;
            default: cg = 5'b11101;
        endcase
        return cg;
    endfunction

    function automatic logic [1:0] ring_to_level(input logic [1:0] idx);
        logic [1:0] lvl;
        case (idx)
            2'd1:    lvl = 2'b01;
            2'd3:    lvl = 2'b11;
            default: lvl = 2'b00;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/tx_enc_framer.sv
module tx_enc_framer
    import tx_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             byp_i,
    input  logic             tx_en_i,
    input  logic             tx_er_i,
    input  logic [NIB_W-1:0] txd_i,
    output logic [CG_W-1:0]  code_o
);

    typedef struct packed {
        frame_st_e st;
    } fr_state_t;

    fr_state_t q, d;

    always_comb begin
        d      = q;
        code_o = CG_IDLE;
        if (byp_i) begin
            code_o = {tx_er_i, txd_i};
            d.st   = FR_IDLE;
        end else begin
            case (q.st)
                FR_IDLE: begin
                    if (tx_en_i) begin
                        code_o = CG_SSD1;
                        d.st   = FR_SSD2;
                    end
                end
                FR_SSD2: begin
                    code_o = CG_SSD2;
                    d.st   = FR_DATA;
                end
                FR_DATA: begin
                    if (!tx_en_i) begin
                        code_o = CG_ESD1;
                        d.st   = FR_ESD2;
                    end else if (tx_er_i) begin
                        code_o = CG_HALT;
                    end else begin
                        code_o = nib_to_cg(txd_i);
                    end
                end
                default: begin
                    code_o = CG_ESD2;
                    d.st   = FR_IDLE;
                end
            endcase
        end
        if (!load_i) begin
            d = q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= FR_IDLE;
        end else begin
            q <= d;
        end
    end

    // R4: the second start delimiter always leads into the data phase
    assert_ssd_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !byp_i && q.st == FR_SSD2) |=> (q.st == FR_DATA));

    // R7: the closing delimiter slot always returns to idle
    assert_esd_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && q.st == FR_ESD2) |=> (q.st == FR_IDLE));

    // R7: framing state only moves on a nibble load
    assert_state_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(q.st));

endmodule

// File: rtl/tx_enc_serializer.sv
module tx_enc_serializer
    import tx_enc_pkg::*;
#(
    parameter int CODE_W = CG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic              load_o,
    output logic              bit_o
);

    localparam int PH_W = $clog2(CODE_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CODE_W - 1);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [CODE_W-1:0] sreg;
    } ser_state_t;

    ser_state_t q, d;

    always_comb begin
        d = q;
        if (q.phase == PH_LAST) begin
            d.phase = '0;
            d.sreg  = code_i;
        end else begin
            d.phase = q.phase + 1'b1;
            d.sreg  = {q.sreg[CODE_W-2:0], 1'b0};
        end
    end

    assign load_o = (q.phase == PH_LAST);
    assign bit_o  = q.sreg[CODE_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase <= '0;
            q.sreg  <= '1;
        end else begin
            q <= d;
        end
    end

    // R2: the phase wraps after the last bit of a group
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (q.phase == '0));

    // R2: inside a group the next lower bit follows
    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o) |=> (bit_o == $past(q.sreg[CODE_W-2])));

endmodule

// File: rtl/tx_enc_scrambler.sv
module tx_enc_scrambler #(
    parameter int LFSR_W   = 11,
    parameter int LFSR_TAP = 9,
    parameter int SEED_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              byp_i,
    input  logic              bit_i,
    output logic              bit_o
);

    localparam int FILL_W = LFSR_W - SEED_W;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } scr_state_t;

    scr_state_t q, d;
    logic       key;

    always_comb begin
        key    = q.lfsr[LFSR_W-1] ^ q.lfsr[LFSR_TAP-1];
        d.lfsr = {q.lfsr[LFSR_W-2:0], key};
        bit_o  = byp_i ? bit_i : (bit_i ^ key);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lfsr <= {{FILL_W{1'b1}}, seed_i};
        end else begin
            q <= d;
        end
    end

    // R8: the cipher register never falls into the all-zero lock-up state
    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lfsr != '0));

    // R8: the register advances by one shift every clock
    assert_lfsr_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q.lfsr[LFSR_W-1:1] == $past(q.lfsr[LFSR_W-2:0])));

endmodule

// File: rtl/tx_enc_line.sv
module tx_enc_line
    import tx_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    input  logic       byp_nrzi_i,
    input  logic       byp_mlt_i,
    output logic [1:0] level_o
);

    typedef struct packed {
        logic       nrzi;
        logic [1:0] idx;
        logic [1:0] lvl;
    } line_state_t;

    line_state_t q, d;

    always_comb begin
        d      = q;
        d.nrzi = byp_nrzi_i ? bit_i : (q.nrzi ^ bit_i);
        if (!byp_mlt_i && q.nrzi) begin
            d.idx = q.idx + 2'd1;
        end
        d.lvl  = byp_mlt_i ? {1'b0, q.nrzi} : ring_to_level(d.idx);
    end

    assign level_o = q.lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.nrzi <= 1'b0;
            q.idx  <= 2'd0;
            q.lvl  <= 2'b00;
        end else begin
            q <= d;
        end
    end

    // R9: a zero leaves the NRZI output where it was
    assert_nrzi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_nrzi_i && !bit_i) |=> $stable(q.nrzi));

    // R10: the ring holds on a zero
    assert_mlt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_mlt_i && !q.nrzi) |=> $stable(q.idx));

    // R10: the ring advances by one on a one
    assert_mlt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_mlt_i && q.nrzi) |=> (q.idx == 2'($past(q.idx) + 2'd1)));

    // R10: the unused code never appears on the line
    assert_level_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != 2'b10));

    // R10: a nonzero level is followed by zero or by itself
    assert_no_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_mlt_i && $past(!byp_mlt_i) && level_o != 2'b00)
        |=> (byp_mlt_i || level_o == 2'b00 || $stable(level_o)));

endmodule

// File: rtl/tx100_sym_enc.sv
module tx100_sym_enc
    import tx_enc_pkg::*;
#(
    parameter int LFSR_W   = 11,
    parameter int LFSR_TAP = 9,
    parameter int SEED_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              tx_er_i,
    input  logic [3:0]        txd_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              byp_code_i,
    input  logic              byp_scr_i,
    input  logic              byp_nrzi_i,
    input  logic              byp_mlt_i,
    output logic              nib_tick_o,
    output logic [1:0]        level_o
);

    logic [CG_W-1:0] code;
    logic            load;
    logic            ser_bit;
    logic            scr_bit;

    tx_enc_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .byp_i   (byp_code_i),
        .tx_en_i (tx_en_i),
        .tx_er_i (tx_er_i),
        .txd_i   (txd_i),
        .code_o  (code)
    );

    tx_enc_serializer #(.CODE_W(CG_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code),
        .load_o (load),
        .bit_o  (ser_bit)
    );

    tx_enc_scrambler #(
        .LFSR_W   (LFSR_W),
        .LFSR_TAP (LFSR_TAP),
        .SEED_W   (SEED_W)
    ) u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed_i),
        .byp_i  (byp_scr_i),
        .bit_i  (ser_bit),
        .bit_o  (scr_bit)
    );

    tx_enc_line u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (scr_bit),
        .byp_nrzi_i (byp_nrzi_i),
        .byp_mlt_i  (byp_mlt_i),
        .level_o    (level_o)
    );

    assign nib_tick_o = load;

    // R1: the line is quiet on the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (level_o == 2'b00 && !nib_tick_o));

endmodule

// File: tb/tx100_sym_enc_tb_top.sv
`timescale 1ns/1ps
module tx100_sym_enc_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en, tx_er;
    logic [3:0] txd;
    logic [4:0] seed;
    logic       bc, bs, bn, bm;
    logic       tick;
    logic [1:0] level;

    always #2.5 clk = ~clk;

    tx100_sym_enc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en_i    (tx_en),
        .tx_er_i    (tx_er),
        .txd_i      (txd),
        .seed_i     (seed),
        .byp_code_i (bc),
        .byp_scr_i  (bs),
        .byp_nrzi_i (bn),
        .byp_mlt_i  (bm),
        .nib_tick_o (tick),
        .level_o    (level)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [5:0] nib_q [0:63];
    int         nib_n;
    logic [1:0] cap   [0:511];
    logic       tcap  [0:511];
    logic [4:0] codes [0:127];
    int         ncyc;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_cg(input logic [3:0] v);
        logic [4:0] t [0:15];
        t[0]  = 5'b11110; t[1]  = 5'b01001; t[2]  = 5'b10100; t[3]  = 5'b10101;
        t[4]  = 5'b01010; t[5]  = 5'b01011; t[6]  = 5'b01110; t[7]  = 5'b01111;
        t[8]  = 5'b10010; t[9]  = 5'b10011; t[10] = 5'b10110; t[11] = 5'b10111;
        t[12] = 5'b11010; t[13] = 5'b11011; t[14] = 5'b11100; t[15] = 5'b11101;
        return t[v];
    endfunction

    task automatic add(input bit en, input bit er, input logic [3:0] d);
        nib_q[nib_n] = {en, er, d};
        nib_n++;
    endtask

    task automatic do_reset(input logic [4:0] s, input bit c, input bit sc,
                            input bit nz, input bit ml);
        rst_n = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0;
        seed = s; bc = c; bs = sc; bn = nz; bm = ml;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(level == 2'b00, "R1", "level in reset", level, 0);
        check(tick == 1'b0, "R1", "tick in reset", tick, 0);
        rst_n = 1'b1;
    endtask

    task automatic run();
        int nidx = 0;
        ncyc = (nib_n + 5) * 5;
        for (int j = 1; j <= ncyc; j++) begin
            @(posedge clk);
            @(negedge clk);
            cap[j]  = level;
            tcap[j] = tick;
            if (tick) begin
                if (nidx < nib_n) {tx_en, tx_er, txd} = nib_q[nidx];
                else {tx_en, tx_er, txd} = 6'd0;
                nidx++;
            end
        end
        tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0;
    endtask

    // expected line levels from the requirement-level model
    task automatic compare(input string req);
        int st = 0;
        int ngrp = ncyc / 5 + 1;
        int bad = 0, first = -1, fa = 0, fe = 0;
        logic [10:0] l = {6'b111111, seed};
        logic nr = 1'b0;
        logic [1:0] mi = 2'd0;
        codes[0] = 5'b11111;
        for (int i = 0; i < ngrp - 1; i++) begin
            logic [5:0] nb = (i < nib_n) ? nib_q[i] : 6'd0;
            logic [4:0] cg = 5'b11111;
            if (bc) cg = nb[4:0];
            else begin
                case (st)
                    0: if (nb[5]) begin cg = 5'b11000; st = 1; end
                    1: begin cg = 5'b10001; st = 2; end
                    2: if (!nb[5]) begin cg = 5'b01101; st = 3; end
                       else if (nb[4]) cg = 5'b00100;
                       else cg = ref_cg(nb[3:0]);
                    default: begin cg = 5'b00111; st = 0; end
                endcase
            end
            codes[i+1] = cg;
        end
        for (int k = 0; k + 2 <= ncyc; k++) begin
            logic b = codes[k/5][4 - (k % 5)];
            logic key = l[10] ^ l[8];
            logic s;
            logic [1:0] ex;
            l = {l[9:0], key};
            s = bs ? b : (b ^ key);
            nr = bn ? s : (nr ^ s);
            if (!bm && nr) mi = mi + 2'd1;
            ex = bm ? {1'b0, nr} : (mi == 2'd1 ? 2'b01 : (mi == 2'd3 ? 2'b11 : 2'b00));
            if (cap[k+2] !== ex) begin
                bad++;
                if (first < 0) begin first = k + 2; fa = cap[k+2]; fe = ex; end
            end
        end
        if (bad != 0) $display("  first mismatch at cycle %0d", first);
        check(bad == 0, req, "line level stream", fa, fe);
    endtask

    function automatic logic [4:0] grp(input int g);
        logic [4:0] r;
        for (int b = 0; b < 5; b++) r[4-b] = cap[5*g + 2 + b][0];
        return r;
    endfunction

    task automatic t_reset_tick();
        nib_n = 0;
        do_reset(5'h00, 1, 1, 1, 1);
        run();
        begin
            int bad = 0;
            for (int j = 1; j <= ncyc; j++) if (tcap[j] !== ((j % 5) == 4)) bad++;
            check(bad == 0, "R2", "tick period", bad, 0);
        end
        check(grp(0) == 5'b11111, "R1", "first group idle", grp(0), 31);
    endtask

    task automatic t_idle();
        int bad = 0;
        nib_n = 0;
        add(0, 1, 4'h3); add(0, 0, 4'hA); add(0, 1, 4'h0);
        do_reset(5'h00, 0, 1, 1, 1);
        run();
        for (int j = 2; j <= ncyc; j++) if (cap[j] !== 2'b01) bad++;
        check(bad == 0, "R3", "idle ones", bad, 0);
        compare("R3");
    endtask

    task automatic t_frame();
        nib_n = 0;
        add(1, 1, 4'h5); add(1, 0, 4'h5); add(1, 0, 4'hD);
        for (int v = 0; v < 16; v++) add(1, 0, 4'(v));
        add(0, 0, 4'h0);
        do_reset(5'h00, 0, 1, 1, 1);
        run();
        check(grp(1) == 5'b11000, "R4", "first delimiter", grp(1), 24);
        check(grp(2) == 5'b10001, "R4", "second delimiter", grp(2), 17);
        check(grp(4) == 5'b11110, "R5", "data 0", grp(4), 30);
        check(grp(20) == 5'b01101, "R7", "end delimiter", grp(20), 13);
        check(grp(21) == 5'b00111, "R7", "end delimiter 2", grp(21), 7);
        compare("R5");
    endtask

    task automatic t_halt();
        nib_n = 0;
        add(1, 0, 4'h5); add(1, 0, 4'h5); add(1, 0, 4'h7);
        add(1, 1, 4'h7); add(1, 0, 4'h2); add(0, 1, 4'h0);
        do_reset(5'h00, 0, 1, 1, 1);
        run();
        check(grp(4) == 5'b00100, "R6", "halt code", grp(4), 4);
        compare("R6");
    endtask

    task automatic t_back_to_back();
        nib_n = 0;
        add(1, 0, 4'h5); add(1, 0, 4'h5); add(1, 0, 4'h9);
        add(0, 0, 4'h0); add(1, 0, 4'h5); add(1, 0, 4'h5);
        add(1, 0, 4'h5); add(1, 0, 4'h1); add(0, 0, 4'h0);
        do_reset(5'h00, 0, 1, 1, 1);
        run();
        check(grp(5) == 5'b00111, "R7", "ignored enable in closing slot", grp(5), 7);
        check(grp(6) == 5'b11000, "R7", "new frame after close", grp(6), 24);
        compare("R7");
    endtask

    task automatic build_frame();
        nib_n = 0;
        add(1, 0, 4'h5); add(1, 0, 4'h5);
        for (int v = 0; v < 20; v++) add(1, 0, 4'((v * 7 + 3) % 16));
        add(0, 0, 4'h0);
    endtask

    task automatic t_scramble();
        build_frame();
        do_reset(5'h13, 0, 0, 1, 1);
        run();
        compare("R8");
        build_frame();
        do_reset(5'h00, 0, 0, 1, 1);
        run();
        compare("R8");
    endtask

    task automatic t_nrzi();
        build_frame();
        do_reset(5'h05, 0, 1, 0, 1);
        run();
        compare("R9");
    endtask

    task automatic t_mlt();
        int bad = 0;
        build_frame();
        do_reset(5'h0A, 0, 0, 0, 0);
        run();
        for (int j = 1; j <= ncyc; j++) if (cap[j] === 2'b10) bad++;
        check(bad == 0, "R10", "no 10 level", bad, 0);
        compare("R10");
        build_frame();
        do_reset(5'h1F, 0, 1, 1, 0);
        run();
        compare("R10");
    endtask

    task automatic t_bypass_code();
        nib_n = 0;
        add(1, 0, 4'h5); add(0, 1, 4'h6); add(1, 1, 4'hF); add(0, 0, 4'h0);
        do_reset(5'h00, 1, 1, 1, 1);
        run();
        check(grp(1) == 5'b00101, "R11", "raw group", grp(1), 5);
        check(grp(2) == 5'b10110, "R11", "raw group with error", grp(2), 22);
        compare("R11");
    endtask

    initial begin
        t_reset_tick();
        t_idle();
        t_frame();
        t_halt();
        t_back_to_back();
        t_scramble();
        t_nrzi();
        t_mlt();
        t_bypass_code();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule